// File: doc/BRIEF.md
# Column-Indexed Lane Shuffle

This block sits in a memory controller on the data path to a DRAM rank built from eight chips. A 64-byte cache line is cut into eight 8-byte lanes, one per chip. Before a line is written, the block permutes those lanes according to the low bits of the line's DRAM column number. On the way back it restores the original order. Lines in neighbouring columns therefore place the same field on different chips. A strided gather that touches one field per line can then be served by several chips at once instead of colliding on one chip.

The permutation is a chain of three butterfly stages. Each stage is driven by one column bit: it either exchanges neighbouring lane groups or passes data through unchanged. Taken together, the stages send lane `i` to lane `i XOR col[2:0]`. This mapping is its own inverse, so the same network serves reads and writes. The direction flag travels with the line only so that it can be traced and checked. A valid/ready handshake carries each line through. When `REGISTERED` is 1 (the default), an output register gives one cycle of latency.

Top module: `col_shuffle`

## Requirements
- R1: Output lane `i XOR col[2:0]` carries input lane `i`, for every lane `i` in 0..7. Lane `i` occupies data bits `[64*i+63 : 64*i]`.
- R2: Butterfly stage k (k = 1, 2, 3) is enabled by column bit k-1. When enabled it exchanges adjacent groups of 2^(k-1) lanes; otherwise it passes data through. A column with bits [2:0] = 0 leaves the line unchanged.
- R3: Column bits above bit 2 have no effect on the lane order.
- R4: Sending a shuffled line through again with the same column restores the original line. The direction flag does not change the data.
- R5: For columns 0, 1, 2 and 3, input lane 0 lands on output lanes 0, 1, 2 and 3 respectively, which are four distinct chips.
- R6: With `REGISTERED`=1, a line accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high right after that edge, which is one cycle of latency.
- R7: While `out_valid` is high and `out_ready` is low, the output data, column and direction hold. `in_ready` is low in that state and high whenever `out_valid` is low.
- R8: After synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.
- R9: `out_col` and `out_dir` carry the column and direction of the line currently on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An input line is offered |
| in_ready | output | 1 | The block can accept a line |
| in_data | input | 512 | Eight 64-bit lanes, lane 0 in the low bits |
| in_col | input | 10 | DRAM column number of the line |
| in_dir | input | 1 | 0 = write path, 1 = read path |
| out_valid | output | 1 | A shuffled line is presented |
| out_ready | input | 1 | The consumer takes the line |
| out_data | output | 512 | Permuted line |
| out_col | output | 10 | Column that travelled with the line |
| out_dir | output | 1 | Direction that travelled with the line |

## Verification
Every result is due exactly one clock edge after the line is accepted. The bench drives each line on a falling edge and checks it on the next falling edge, once the single output register has loaded. The sweep covers all 1024 column values, and the expected lane order is computed arithmetically from the XOR rule. In the stall scenario the output is sampled on each falling edge while `out_ready` is low, to confirm it holds. The replacement line is checked on the falling edge after the edge on which the consumer takes the held line. The involution check feeds each output back in and samples one edge later.

// File: rtl/shuf_pkg.sv
// Package: shared types and helpers for the column-indexed lane shuffle.
// Assumes the lane count is a power of two.
package shuf_pkg;

    // Direction tag carried with each line; it never alters the permutation.
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    // Destination lane of source lane src for a given stage-select value.
    function automatic int unsigned lane_target(input int unsigned src,
                                                input int unsigned sel);
        return src ^ sel;
    endfunction

endpackage

// File: rtl/shuf_stage.sv
// Module: one butterfly stage. When en is high, every lane trades places with
// the lane SPAN positions away inside its 2*SPAN group; otherwise it is a wire.
// Assumes SPAN is a power of two below LANES.
module shuf_stage #(
    parameter int LANES  = 8,
    parameter int LANE_W = 64,
    parameter int SPAN   = 1
) (
    input  logic                    en,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);

    // Per-lane 2:1 select between the straight and the exchanged source.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PARTNER = i ^ SPAN;
        assign dout[i*LANE_W +: LANE_W] = en ? din[PARTNER*LANE_W +: LANE_W]
                                             : din[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/shuf_network.sv
// Module: chain of log2(LANES) butterfly stages, stage k switched by col bit k.
// Only the low STAGES column bits are looked at; the rest are ignored.
module shuf_network #(
    parameter int LANES  = 8,
    parameter int LANE_W = 64,
    parameter int COL_W  = 10
) (
    input  logic [COL_W-1:0]        col,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout
);

    localparam int STAGES = $clog2(LANES);

    logic [STAGES:0][LANES*LANE_W-1:0] chain;

    // Network entry point.
    assign chain[0] = din;

    // One stage per select bit, span doubling from stage to stage.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        shuf_stage #(
            .LANES (LANES),
            .LANE_W(LANE_W),
            .SPAN  (1 << k)
        ) u_stage (
            .en  (col[k]),
            .din (chain[k]),
            .dout(chain[k+1])
        );
    end

    // Network exit point.
    assign dout = chain[STAGES];

endmodule

// File: rtl/shuf_pipe.sv
// Module: optional one-deep output register with valid/ready handshake.
// REGISTERED=1 gives one cycle of latency and full throughput; REGISTERED=0
// is a pure wire. Assumes a synchronous active-low reset.
module shuf_pipe #(
    parameter int PW         = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [PW-1:0] in_pay,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_pay
);

    if (REGISTERED) begin : g_reg
        logic          vld_q;
        logic [PW-1:0] pay_q;

        // Accept when empty or when the held line is leaving.
        assign in_ready  = !vld_q || out_ready;
        assign out_valid = vld_q;
        assign out_pay   = pay_q;

        // Valid flag: set on accept, cleared when drained with nothing new.
        always_ff @(posedge clk) begin
            if (!rst_n)        vld_q <= 1'b0;
            else if (in_ready) vld_q <= in_valid;
        end

        // Payload register: loads only on an accepted line.
        always_ff @(posedge clk) begin
            if (in_valid && in_ready) pay_q <= in_pay;
        end

        p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> out_valid);
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
        p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> in_ready);
        p_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=> (out_pay == $past(in_pay)));
    end else begin : g_wire
        // Pass-through: handshake and payload go straight across.
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign out_pay   = in_pay;
    end

endmodule

// File: rtl/col_shuffle.sv
// Module: top of the column-indexed lane shuffle. Permutes the chip lanes of a
// cache line by lane XOR col[2:0] and presents it through an optional output
// register. The same mapping serves both directions because it is self-inverse.
// Assumes LANES is a power of two and COL_W >= log2(LANES).
module col_shuffle #(
    parameter int LANES      = 8,
    parameter int LANE_W     = 64,
    parameter int COL_W      = 10,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*LANE_W-1:0] in_data,
    input  logic [COL_W-1:0]        in_col,
    input  logic                    in_dir,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] out_data,
    output logic [COL_W-1:0]        out_col,
    output logic                    out_dir
);

    import shuf_pkg::*;

    localparam int DW     = LANES * LANE_W;
    localparam int STAGES = $clog2(LANES);
    localparam int PW     = DW + COL_W + 1;

    logic [DW-1:0] net_out;
    dir_e          dir_in;
    logic [PW-1:0] pay_in;
    logic [PW-1:0] pay_out;

    // Lane permutation network.
    shuf_network #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .COL_W (COL_W)
    ) u_net (
        .col (in_col),
        .din (in_data),
        .dout(net_out)
    );

    // Tag direction with its enumerated meaning and bundle the payload.
    assign dir_in = dir_e'(in_dir);
    assign pay_in = {net_out, in_col, dir_in};

    // Output staging.
    shuf_pipe #(
        .PW        (PW),
        .REGISTERED(REGISTERED)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_pay   (pay_in),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_pay  (pay_out)
    );

    // Unbundle the presented payload.
    assign out_data = pay_out[PW-1 -: DW];
    assign out_col  = pay_out[COL_W:1];
    assign out_dir  = pay_out[0];

    p_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (net_out[lane_target(0, int'(in_col[STAGES-1:0]))*LANE_W +: LANE_W]
                      == in_data[LANE_W-1:0]));
    p_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_col[STAGES-1:0] == '0)) |-> (net_out == in_data));

endmodule

// File: tb/col_shuffle_test.sv
module col_shuffle_test;

    localparam int LANES = 8;
    localparam int LW    = 64;
    localparam int CW    = 10;
    localparam int DW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_dir;
    logic [DW-1:0] in_data;
    logic [CW-1:0] in_col;
    logic          out_valid, out_ready, out_dir;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_col;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    col_shuffle uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_col(in_col), .in_dir(in_dir),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_col(out_col), .out_dir(out_dir)
    );

    function automatic logic [DW-1:0] make_line(input int seed);
        logic [DW-1:0] l;
        for (int i = 0; i < LANES; i++) l[i*LW +: LW] = {32'(seed), 32'(i + 1)};
        return l;
    endfunction

    function automatic logic [DW-1:0] exp_shuf(input logic [DW-1:0] l, input logic [CW-1:0] c);
        logic [DW-1:0] o;
        for (int i = 0; i < LANES; i++) o[(i ^ int'(c[2:0]))*LW +: LW] = l[i*LW +: LW];
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Push one line with out_ready high, return the presented line.
    task automatic push(input logic [DW-1:0] d, input logic [CW-1:0] c, input logic dr,
                        output logic [DW-1:0] got);
        @(negedge clk);
        in_data = d; in_col = c; in_dir = dr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        // R6: output valid one edge after acceptance
        chk(out_valid == 1'b1, "R6", DW'(out_valid), DW'(1));
        // R9: column and direction follow the line
        chk(out_col == c && out_dir == dr, "R9", DW'({out_col, out_dir}), DW'({c, dr}));
        got = out_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got, back, ref_line, hi, lo;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_col = '0; in_dir = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(out_valid == 1'b0, "R8", DW'(out_valid), DW'(0));
        chk(in_ready == 1'b1, "R8", DW'(in_ready), DW'(1));
        rst_n = 1'b1;

        // R1 sweep over every column value, alternating direction (R4: dir no effect)
        for (int c = 0; c < (1 << CW); c++) begin
            ref_line = make_line(c * 7 + 3);
            push(ref_line, CW'(c), c[0], got);
            chk(got == exp_shuf(ref_line, CW'(c)), "R1", got, exp_shuf(ref_line, CW'(c)));
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", DW'(out_valid), DW'(0));
        end

        // R2: single stages, expected built lane by lane from the group-swap rule
        for (int k = 0; k < 3; k++) begin
            logic [DW-1:0] e;
            ref_line = make_line(100 + k);
            for (int i = 0; i < LANES; i++) begin
                int src;
                src = ((i >> k) & 1) ? i - (1 << k) : i + (1 << k);
                e[i*LW +: LW] = ref_line[src*LW +: LW];
            end
            push(ref_line, CW'(1 << k), 1'b0, got);
            chk(got == e, "R2", got, e);
        end
        ref_line = make_line(200);
        push(ref_line, CW'(0), 1'b0, got);
        chk(got == ref_line, "R2", got, ref_line);

        // R3: high column bits ignored
        ref_line = make_line(300);
        push(ref_line, CW'(10'h3F5), 1'b0, hi);
        push(ref_line, CW'(10'h005), 1'b0, lo);
        chk(hi == lo, "R3", hi, lo);

        // R4: involution, write then read restores the line
        for (int c = 0; c < 16; c++) begin
            ref_line = make_line(400 + c);
            push(ref_line, CW'(c * 37), 1'b0, got);
            push(got, CW'(c * 37), 1'b1, back);
            chk(back == ref_line, "R4", back, ref_line);
        end

        // R5: lane 0 of columns 0..3 lands on chips 0..3
        for (int c = 0; c < 4; c++) begin
            ref_line = make_line(500 + c);
            push(ref_line, CW'(c), 1'b0, got);
            chk(got[c*LW +: LW] == ref_line[0 +: LW], "R5",
                DW'(got[c*LW +: LW]), DW'(ref_line[0 +: LW]));
        end

        // R7: back-pressure
        begin
            logic [DW-1:0] a, b;
            a = make_line(600); b = make_line(601);
            @(negedge clk);
            out_ready = 1'b0;
            in_data = a; in_col = CW'(3); in_dir = 1'b0; in_valid = 1'b1;
            @(negedge clk);
            in_data = b; in_col = CW'(6); in_dir = 1'b1;
            chk(in_ready == 1'b0, "R7", DW'(in_ready), DW'(0));
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                chk(out_valid && out_data == exp_shuf(a, CW'(3)) && out_col == CW'(3),
                    "R7", out_data, exp_shuf(a, CW'(3)));
            end
            out_ready = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid && out_data == exp_shuf(b, CW'(6)) && out_dir == 1'b1,
                "R7", out_data, exp_shuf(b, CW'(6)));
            @(negedge clk);
            chk(out_valid == 1'b0 && in_ready == 1'b1, "R7", DW'({out_valid, in_ready}), DW'(1));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule